// File: doc/BRIEF.md
# Fixed-Point Requantizing Elementwise Multiplier

This block multiplies two streams of unsigned 8-bit quantized values element by element and returns an unsigned 8-bit quantized result. It uses integer arithmetic only. Each operand carries its own zero point, which is removed before the product is formed. The real-valued scale ratio between the input and output domains arrives as a precomputed unsigned integer multiplier and a right-shift count, so the rescale step is a wide multiply followed by a rounded arithmetic shift. The output zero point is then added and the value is clamped to the 8-bit range.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. The three pipeline stages advance together whenever the output register is empty or being drained, so a stalled consumer freezes the whole pipe and no element is lost. The zero points, the multiplier and the shift are static configuration inputs. They must be held steady while elements are in flight.

Top module: `qmul_requant`

## Requirements
- R1: After reset `out_valid` is 0, and `in_ready` is 1 even while `out_ready` is 0.
- R2: Each operand has its own zero point subtracted (a - zp_a, b - zp_b) as signed values before multiplication, so values below the zero point give negative differences.
- R3: With shift s > 0, the scaled value is floor((d * mult + 2^(s-1)) / 2^s), where d is the signed difference product. Halves round upward, also for negative values (for example -1.5 becomes -1 and 1.5 becomes 2).
- R4: With shift 0 no rounding term is added, and the scaled value is exactly d * mult.
- R5: The output zero point zp_o is added to the scaled value after the shift.
- R6: The result is clamped to 0..255: sums below 0 give 0, and sums above 255 give 255.
- R7: `mult` is treated as unsigned over its full 32 bits (values at or above 2^31 stay positive). Shift counts up to 31 are accepted. The intermediates are wide enough that a product magnitude of 65025 times 2^32-1 does not overflow.
- R8: With `out_ready` held high, a result is presented on `out_valid`/`y` after the third rising edge, counting the edge that accepts the element.
- R9: While `out_valid` is 1 and `out_ready` is 0, `y` and `out_valid` hold and `in_ready` is 0. Results leave in acceptance order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| zp_a | input | 8 | Zero point of operand a |
| zp_b | input | 8 | Zero point of operand b |
| zp_o | input | 8 | Zero point of the result |
| mult | input | 32 | Unsigned rescale multiplier |
| shift | input | 5 | Right-shift count, 0..31 |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Operand pair accepted when high together with in_valid |
| a | input | 8 | Operand a |
| b | input | 8 | Operand b |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready for result |
| y | output | 8 | Quantized result |

## Verification
The embedded assertions check the flow-control behaviour on every cycle. A held result stays stable while the consumer stalls, a valid stage moves to the next one on every advancing edge, and the stage registers stay frozen during a stall. The arithmetic can only be shown by the bench scenarios: zero-point handling, the rounding direction on halves and negatives, saturation at both ends, and the unsigned 32-bit multiplier with large shifts. Each of these is compared against an independent 64-bit integer model. The ordering and completeness of results under random stalls and gaps is also shown only by the bench.

// File: rtl/qmul_requant.sv
`timescale 1ns/1ps
module qmul_requant #(
  parameter int DW = 8,
  parameter int MW = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] zp_a,
  input  logic [DW-1:0] zp_b,
  input  logic [DW-1:0] zp_o,
  input  logic [MW-1:0] mult,
  input  logic [SW-1:0] shift,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] y
);
  localparam int DD = DW + 1;
  localparam int PW = 2 * DD;
  localparam int XW = 64;
  localparam logic signed [XW-1:0] OMAX = XW'((1 << DW) - 1);

  logic en;
  logic v1, v2;
  logic signed [DD-1:0] da, db;
  logic signed [PW-1:0] pr;
  logic signed [XW-1:0] pr_x, m_x, sc, rnd, sh, biased;
  logic [DW-1:0] sat;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      da <= $signed({1'b0, a}) - $signed({1'b0, zp_a});
      db <= $signed({1'b0, b}) - $signed({1'b0, zp_b});
      pr <= da * db;
      y  <= sat;
    end
  end

  assign pr_x   = {{(XW-PW){pr[PW-1]}}, pr};
  assign m_x    = {{(XW-MW){1'b0}}, mult};
  assign sc     = pr_x * m_x;
  assign rnd    = (shift == '0) ? '0 : ({{(XW-1){1'b0}}, 1'b1} << (shift - SW'(1)));
  assign sh     = (sc + rnd) >>> shift;
  assign biased = sh + {{(XW-DW){1'b0}}, zp_o};

  always_comb begin
    if (biased < 0)         sat = '0;
    else if (biased > OMAX) sat = '1;
    else                    sat = biased[DW-1:0];
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(y));
  assert_s1_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    v1 && in_ready |=> v2);
  assert_s2_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    v2 && in_ready |=> out_valid);
  assert_s1_frz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && v1 |=> $stable(da) && $stable(db) && v1);
  assert_s2_frz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && v2 |=> $stable(pr) && v2);
endmodule

// File: tb/sim_qmul_requant.sv
`timescale 1ns/1ps
module sim_qmul_requant;
  logic clk = 0, rst_n = 0;
  logic [7:0] zp_a = 0, zp_b = 0, zp_o = 0, a = 0, b = 0, y;
  logic [31:0] mult = 0;
  logic [4:0] shift = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qmul_requant u0 (.clk(clk), .rst_n(rst_n), .zp_a(zp_a), .zp_b(zp_b), .zp_o(zp_o),
    .mult(mult), .shift(shift), .in_valid(in_valid), .in_ready(in_ready), .a(a), .b(b),
    .out_valid(out_valid), .out_ready(out_ready), .y(y));

  function automatic int model(int av, int bv);
    longint d, p;
    d = longint'(av - int'(zp_a)) * longint'(bv - int'(zp_b));
    p = d * longint'({32'b0, mult});
    if (shift != 0) p = p + (64'sd1 <<< (shift - 1));
    p = (p >>> shift) + longint'(zp_o);
    if (p < 0) return 0;
    if (p > 255) return 255;
    return int'(p);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(int za, int zb, int zo, longint m, int s);
    zp_a = 8'(za); zp_b = 8'(zb); zp_o = 8'(zo); mult = 32'(m); shift = 5'(s);
  endtask

  task automatic single(int av, int bv, int expv, string tag, bit lat);
    int k;
    @(negedge clk);
    in_valid = 1; a = 8'(av); b = 8'(bv); out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    k = 1;
    while (!out_valid && k < 10) begin
      @(negedge clk);
      k++;
    end
    chk(int'(y) == expv, tag, int'(y), expv);
    chk(int'(y) == model(av, bv), {tag, " model"}, int'(y), model(av, bv));
    if (lat) chk(k == 3, "R8 latency", k, 3);
    @(negedge clk);
  endtask

  task automatic stream(int n, int rdy, int vld, string tag);
    int q[$];
    int sent = 0, got = 0, guard = 0, e;
    bit hold = 0, pend = 0;
    logic [7:0] last = 0;
    while (got < n && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (hold) chk(out_valid && y == last, "R9 hold", int'(y), int'(last));
      out_ready = ($urandom % 100) < rdy;
      if (!pend) begin
        if (sent < n && ($urandom % 100) < vld) begin
          in_valid = 1; a = 8'($urandom); b = 8'($urandom); pend = 1;
        end else in_valid = 0;
      end
      #1;
      if (out_valid && !out_ready) chk(!in_ready, "R9 in_ready low", int'(in_ready), 0);
      if (in_valid && in_ready) begin
        q.push_back(model(int'(a), int'(b)));
        sent++; pend = 0;
      end
      if (out_valid && out_ready) begin
        e = (q.size() > 0) ? q.pop_front() : -1;
        chk(int'(y) == e, tag, int'(y), e);
        got++;
      end
      hold = out_valid && !out_ready;
      last = y;
    end
    chk(got == n, {tag, " count"}, got, n);
    @(negedge clk);
    in_valid = 0;
    out_ready = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_zero_point;
    cfg(128, 128, 128, 214748365, 31);
    single(138, 148, 148, "R2 R5 ratio 0.1 shift 31", 1);
    single(118, 148, 108, "R2 negative difference", 0);
    stream(40, 100, 100, "R2 R5 stream");
  endtask

  task automatic t_shift8;
    cfg(128, 128, 128, 26, 8);
    single(138, 148, 148, "R3 ratio 0.1 shift 8", 0);
    stream(40, 100, 100, "R3 stream shift 8");
  endtask

  task automatic t_shift0;
    cfg(100, 100, 5, 1, 0);
    single(103, 104, 17, "R4 shift 0", 0);
    cfg(100, 100, 5, 3, 0);
    single(103, 104, 41, "R4 shift 0 mult 3", 0);
  endtask

  task automatic t_round;
    cfg(100, 100, 10, 1, 1);
    single(103, 101, 12, "R3 half up positive", 0);
    single(97, 101, 9, "R3 half up negative", 0);
    single(102, 101, 11, "R3 exact", 0);
  endtask

  task automatic t_sat;
    cfg(0, 0, 0, 1, 0);
    single(255, 255, 255, "R6 upper clamp", 0);
    cfg(255, 0, 0, 1, 0);
    single(0, 255, 0, "R6 lower clamp", 0);
    cfg(0, 0, 250, 1, 0);
    single(2, 5, 255, "R6 R5 zero point overflow", 0);
  endtask

  task automatic t_wide;
    cfg(1, 0, 100, 64'hFFFF_FFFF, 31);
    single(2, 1, 102, "R7 full multiplier positive", 0);
    single(0, 1, 98, "R7 full multiplier negative", 0);
    cfg(0, 0, 0, 64'hFFFF_FFFF, 31);
    single(255, 255, 255, "R7 max magnitude", 0);
    stream(40, 100, 100, "R7 stream");
  endtask

  task automatic t_stall;
    cfg(77, 140, 30, 123456789, 27);
    stream(200, 40, 70, "R9 random stall");
    cfg(3, 250, 200, 5000, 12);
    stream(100, 20, 100, "R9 heavy stall");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_zero_point();
    t_shift8();
    t_shift0();
    t_round();
    t_sat();
    t_wide();
    t_stall();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule